// File: doc/BRIEF.md
# Register Readiness and Tag Table

This block keeps, for every architectural register, one ready bit and the tag of the in-flight instruction that will produce the register's next value. It is used at the rename point of an out-of-order core. Each cycle, a group of up to `DispWidth` instructions arrives in program order. For every source operand of every instruction, the block returns whether the operand is available and, if it is not, which producer tag to wait on. It then records each destination as pending under the tag of the instruction that writes it. Tags are sequence numbers and are never reused.

Finished instructions report back on up to `CmplWidth` completion lanes per cycle. A lane names a register and a tag. The register becomes ready only if that tag is still the one the table holds for it, so a result from an overtaken producer cannot clear a newer pending write. Completions take effect without any retirement step. A completion is also forwarded to source lookups made in the same cycle. Register values are not stored; only readiness and tags are kept.

Top module: `rename_status_table`

## Requirements
- R1: After reset every register reads as ready.
- R2: A register specifier is `SpecW` = 8 bits wide. Values 0 to 127 name a register, and any value with bit 7 set (for example 8'hFF, that is -1) means the operand is absent. An absent source reports ready = 1 and tag = 0.
- R3: A valid instruction with an absent destination changes no table entry. In particular, 8'hFF does not alias to register 127 and 8'h80 does not alias to register 0.
- R4: A valid instruction with a present destination leaves that register pending under the instruction's tag from the next cycle on. Later lookups report ready = 0 and that tag.
- R5: A completion whose tag equals the tag held for its register makes the register ready from the next cycle on.
- R6: A completion whose tag differs from the tag held for its register has no effect, neither on the table nor on same-cycle lookups.
- R7: Within one group, a source that matches the destination of an earlier valid slot reports ready = 0 and the tag of the youngest such earlier slot.
- R8: A slot's source is not affected by its own destination or by destinations of later slots in the same group. It reads the state from before the group.
- R9: When several slots of one group write the same register, the table keeps the tag of the youngest of them.
- R10: When a completion and a new dispatch hit the same register in one cycle, the register ends up pending under the new tag.
- R11: All completion lanes are applied in the same cycle, independently of each other.
- R12: A slot with its valid bit low neither writes the table nor bypasses to later slots.
- R13: A matching completion in the current cycle makes same-cycle lookups of that register report ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dispValid | input | DispWidth | Slot valid bits; slot 0 is the oldest |
| dispTag | input | DispWidth x TagWidth | Sequence tag of each slot |
| dispDst | input | DispWidth x SpecW | Destination specifier of each slot |
| dispSrc1 | input | DispWidth x SpecW | First source specifier of each slot |
| dispSrc2 | input | DispWidth x SpecW | Second source specifier of each slot |
| src1Ready | output | DispWidth | First source is available |
| src1Tag | output | DispWidth x TagWidth | Producer tag of the first source when not ready |
| src2Ready | output | DispWidth | Second source is available |
| src2Tag | output | DispWidth x TagWidth | Producer tag of the second source when not ready |
| cmplValid | input | CmplWidth | Completion lane valid bits |
| cmplReg | input | CmplWidth x SpecW | Register written by each completing instruction |
| cmplTag | input | CmplWidth x TagWidth | Tag of each completing instruction |

## Verification
The bench targets the priority corners. A stale completion arriving on the same cycle as a newer dispatch must lose, and a design that let the completion win would report a pending register as ready early. Groups in which several slots write and read the same registers check that bypass picks the youngest earlier writer and never a later one. A table that got this wrong would hand out the wrong wait tag, or would make an instruction wait on itself. The bench also drives completions in the same cycle as lookups, to catch a missing forward path that costs a wakeup cycle. It drives negative specifiers that could alias onto registers 0 and 127.

// File: rtl/rst_pkg.sv
package rst_pkg;
  parameter int NumRegs   = 128;
  parameter int DispWidth = 4;
  parameter int TagWidth  = 16;
  parameter int CmplWidth = 8;

  localparam int RegIdxW = $clog2(NumRegs);
  localparam int SpecW   = RegIdxW + 1;
  localparam int SlotW   = (DispWidth > 1) ? $clog2(DispWidth) : 1;

  typedef logic [SpecW-1:0]    spec_t;
  typedef logic [TagWidth-1:0] tag_t;
  typedef logic [RegIdxW-1:0]  regIdx_t;

  // strobes from the control to the storage
  typedef struct packed {
    logic [NumRegs-1:0]            setPend;
    logic [NumRegs-1:0]            wake;
    logic [NumRegs-1:0][SlotW-1:0] pendSlot;
  } tableStrobe_t;

  typedef struct packed {
    logic ready;
    tag_t tag;
  } srcInfo_t;

  // top specifier bit set means "no operand"
  function automatic logic isPresent(spec_t s);
    return !s[SpecW-1];
  endfunction

  function automatic regIdx_t regOf(spec_t s);
    return s[RegIdxW-1:0];
  endfunction
endpackage

// File: rtl/rst_ctrl.sv
module rst_ctrl
  import rst_pkg::*;
(
  input  logic [DispWidth-1:0]               dispValid,
  input  logic [DispWidth-1:0][SpecW-1:0]    dispDst,
  input  logic [CmplWidth-1:0]               cmplValid,
  input  logic [CmplWidth-1:0][SpecW-1:0]    cmplReg,
  input  logic [CmplWidth-1:0][TagWidth-1:0] cmplTag,
  input  logic [NumRegs-1:0]                 readyQ,
  input  logic [NumRegs-1:0][TagWidth-1:0]   tagQ,
  output tableStrobe_t                       strobe
);
  always_comb begin
    strobe = '0;
    // ascending slot order: the youngest writer of a register is kept
    for (int i = 0; i < DispWidth; i++) begin
      if (dispValid[i] && isPresent(dispDst[i])) begin
        strobe.setPend[regOf(dispDst[i])]  = 1'b1;
        strobe.pendSlot[regOf(dispDst[i])] = SlotW'(i);
      end
    end
    // a completion wakes only the producer the table still waits on
    for (int c = 0; c < CmplWidth; c++) begin
      if (cmplValid[c] && isPresent(cmplReg[c])
          && !readyQ[regOf(cmplReg[c])]
          && (tagQ[regOf(cmplReg[c])] == cmplTag[c])) begin
        strobe.wake[regOf(cmplReg[c])] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rst_datapath.sv
module rst_datapath
  import rst_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [DispWidth-1:0]              dispValid,
  input  logic [DispWidth-1:0][TagWidth-1:0] dispTag,
  input  logic [DispWidth-1:0][SpecW-1:0]   dispDst,
  input  logic [DispWidth-1:0][SpecW-1:0]   dispSrc1,
  input  logic [DispWidth-1:0][SpecW-1:0]   dispSrc2,
  input  tableStrobe_t                      strobe,
  output logic [NumRegs-1:0]                readyQ,
  output logic [NumRegs-1:0][TagWidth-1:0]  tagQ,
  output logic [DispWidth-1:0]              src1Ready,
  output logic [DispWidth-1:0][TagWidth-1:0] src1Tag,
  output logic [DispWidth-1:0]              src2Ready,
  output logic [DispWidth-1:0][TagWidth-1:0] src2Tag
);
  // storage: a new pending mark beats a wakeup on the same register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ <= '1;
      tagQ   <= '0;
    end else begin
      for (int r = 0; r < NumRegs; r++) begin
        if (strobe.setPend[r]) begin
          readyQ[r] <= 1'b0;
          tagQ[r]   <= dispTag[strobe.pendSlot[r]];
        end else if (strobe.wake[r]) begin
          readyQ[r] <= 1'b1;
        end
      end
    end
  end

  // table read with same-cycle wakeup, then override by older slots of the group
  function automatic srcInfo_t lookup(spec_t s, int slot);
    srcInfo_t res;
    regIdx_t  idx;
    res.ready = 1'b1;
    res.tag   = '0;
    if (isPresent(s)) begin
      idx       = regOf(s);
      res.ready = readyQ[idx] | strobe.wake[idx];
      res.tag   = tagQ[idx];
      for (int j = 0; j < DispWidth; j++) begin
        if (j < slot && dispValid[j] && isPresent(dispDst[j])
            && regOf(dispDst[j]) == idx) begin
          res.ready = 1'b0;
          res.tag   = dispTag[j];
        end
      end
    end
    return res;
  endfunction

  for (genvar i = 0; i < DispWidth; i++) begin : g_slot
    srcInfo_t info1;
    srcInfo_t info2;
    always_comb begin
      info1 = lookup(dispSrc1[i], i);
      info2 = lookup(dispSrc2[i], i);
    end
    assign src1Ready[i] = info1.ready;
    assign src1Tag[i]   = info1.tag;
    assign src2Ready[i] = info2.ready;
    assign src2Tag[i]   = info2.tag;
  end
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
  import rst_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [DispWidth-1:0]                dispValid,
  input  logic [DispWidth-1:0][TagWidth-1:0]  dispTag,
  input  logic [DispWidth-1:0][SpecW-1:0]     dispDst,
  input  logic [DispWidth-1:0][SpecW-1:0]     dispSrc1,
  input  logic [DispWidth-1:0][SpecW-1:0]     dispSrc2,
  output logic [DispWidth-1:0]                src1Ready,
  output logic [DispWidth-1:0][TagWidth-1:0]  src1Tag,
  output logic [DispWidth-1:0]                src2Ready,
  output logic [DispWidth-1:0][TagWidth-1:0]  src2Tag,
  input  logic [CmplWidth-1:0]                cmplValid,
  input  logic [CmplWidth-1:0][SpecW-1:0]     cmplReg,
  input  logic [CmplWidth-1:0][TagWidth-1:0]  cmplTag
);
  tableStrobe_t                    strobe;
  logic [NumRegs-1:0]              readyQ;
  logic [NumRegs-1:0][TagWidth-1:0] tagQ;

  rst_ctrl u_ctrl (
    .dispValid (dispValid),
    .dispDst   (dispDst),
    .cmplValid (cmplValid),
    .cmplReg   (cmplReg),
    .cmplTag   (cmplTag),
    .readyQ    (readyQ),
    .tagQ      (tagQ),
    .strobe    (strobe)
  );

  rst_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dispValid (dispValid),
    .dispTag   (dispTag),
    .dispDst   (dispDst),
    .dispSrc1  (dispSrc1),
    .dispSrc2  (dispSrc2),
    .strobe    (strobe),
    .readyQ    (readyQ),
    .tagQ      (tagQ),
    .src1Ready (src1Ready),
    .src1Tag   (src1Tag),
    .src2Ready (src2Ready),
    .src2Tag   (src2Tag)
  );
endmodule

// File: rtl/rst_checker.sv
module rst_checker
  import rst_pkg::*;
(
  input logic                                clk,
  input logic                                rstN,
  input logic [DispWidth-1:0]                dispValid,
  input logic [DispWidth-1:0][TagWidth-1:0]  dispTag,
  input logic [DispWidth-1:0][SpecW-1:0]     dispDst,
  input logic [DispWidth-1:0][SpecW-1:0]     dispSrc1,
  input logic [DispWidth-1:0]                src1Ready,
  input logic [DispWidth-1:0][TagWidth-1:0]  src1Tag,
  input logic [CmplWidth-1:0]                cmplValid,
  input logic [CmplWidth-1:0][SpecW-1:0]     cmplReg,
  input logic [CmplWidth-1:0][TagWidth-1:0]  cmplTag,
  input logic [NumRegs-1:0]                  readyQ,
  input logic [NumRegs-1:0][TagWidth-1:0]    tagQ
);
  localparam int Last = DispWidth - 1;

  logic [NumRegs-1:0] dispHit;
  always_comb begin
    dispHit = '0;
    for (int i = 0; i < DispWidth; i++)
      if (dispValid[i] && isPresent(dispDst[i])) dispHit[regOf(dispDst[i])] = 1'b1;
  end

  p_reset_all_ready_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (&readyQ));

  for (genvar i = 0; i < DispWidth; i++) begin : g_abs
    p_absent_src_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
      !isPresent(dispSrc1[i]) |-> (src1Ready[i] && src1Tag[i] == '0));
  end

  p_youngest_pends_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid[Last] && isPresent(dispDst[Last])) |=>
      (!readyQ[$past(regOf(dispDst[Last]))]
       && tagQ[$past(regOf(dispDst[Last]))] == $past(dispTag[Last])));

  for (genvar c = 0; c < CmplWidth; c++) begin : g_cmpl
    p_match_wakes_r5: assert property (@(posedge clk) disable iff (!rstN)
      (cmplValid[c] && isPresent(cmplReg[c])
       && cmplTag[c] == tagQ[regOf(cmplReg[c])]
       && !dispHit[regOf(cmplReg[c])]) |=> readyQ[$past(regOf(cmplReg[c]))]);
  end

  if (DispWidth > 1) begin : g_byp
    p_group_bypass_r7: assert property (@(posedge clk) disable iff (!rstN)
      (dispValid[0] && isPresent(dispDst[0]) && dispSrc1[1] == dispDst[0]) |->
        (!src1Ready[1] && src1Tag[1] == dispTag[0]));
  end
endmodule

bind rename_status_table rst_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dispValid (dispValid),
  .dispTag   (dispTag),
  .dispDst   (dispDst),
  .dispSrc1  (dispSrc1),
  .src1Ready (src1Ready),
  .src1Tag   (src1Tag),
  .cmplValid (cmplValid),
  .cmplReg   (cmplReg),
  .cmplTag   (cmplTag),
  .readyQ    (readyQ),
  .tagQ      (tagQ)
);

// File: tb/rename_status_table_bench.sv
module rename_status_table_bench;
  import rst_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DispWidth-1:0]                dispValid;
  logic [DispWidth-1:0][TagWidth-1:0]  dispTag;
  logic [DispWidth-1:0][SpecW-1:0]     dispDst, dispSrc1, dispSrc2;
  logic [DispWidth-1:0]                src1Ready, src2Ready;
  logic [DispWidth-1:0][TagWidth-1:0]  src1Tag, src2Tag;
  logic [CmplWidth-1:0]                cmplValid;
  logic [CmplWidth-1:0][SpecW-1:0]     cmplReg;
  logic [CmplWidth-1:0][TagWidth-1:0]  cmplTag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  rename_status_table u_rename_status_table (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispTag(dispTag),
    .dispDst(dispDst), .dispSrc1(dispSrc1), .dispSrc2(dispSrc2),
    .src1Ready(src1Ready), .src1Tag(src1Tag), .src2Ready(src2Ready), .src2Tag(src2Tag),
    .cmplValid(cmplValid), .cmplReg(cmplReg), .cmplTag(cmplTag)
  );

  // one cycle per row: slot 0 dispatch, completion lane 0, expected first source of slot 0
  typedef struct packed {
    logic        v;
    logic [7:0]  dst;
    logic [7:0]  src;
    logic [15:0] tag;
    logic        cv;
    logic [7:0]  creg;
    logic [15:0] ctag;
    logic        expRdy;
    logic [15:0] expTag;
    logic [7:0]  req;
  } vec_t;

  localparam int NVec = 12;
  localparam vec_t Vecs [NVec] = '{
    '{1'b1, 8'd5,   8'd5,   16'd0, 1'b0, 8'd0, 16'd0, 1'b1, 16'd0, 8'd8 },  // R8 own dst unseen
    '{1'b1, 8'd6,   8'd5,   16'd1, 1'b0, 8'd0, 16'd0, 1'b0, 16'd0, 8'd4 },  // R4
    '{1'b1, 8'hFF,  8'd6,   16'd2, 1'b0, 8'd0, 16'd0, 1'b0, 16'd1, 8'd4 },  // R4
    '{1'b0, 8'd5,   8'd5,   16'd0, 1'b1, 8'd5, 16'd0, 1'b1, 16'd0, 8'd13},  // R13 forward
    '{1'b1, 8'd7,   8'd5,   16'd3, 1'b0, 8'd0, 16'd0, 1'b1, 16'd0, 8'd5 },  // R5 woken, R12 no write
    '{1'b1, 8'hFF,  8'd6,   16'd4, 1'b1, 8'd6, 16'd9, 1'b0, 16'd1, 8'd6 },  // R6 stale tag
    '{1'b1, 8'd6,   8'hFF,  16'd5, 1'b1, 8'd6, 16'd1, 1'b1, 16'd0, 8'd2 },  // R2 absent
    '{1'b1, 8'hFF,  8'd6,   16'd6, 1'b1, 8'd6, 16'd1, 1'b0, 16'd5, 8'd10},  // R10 pend won
    '{1'b0, 8'd0,   8'd6,   16'd0, 1'b1, 8'd6, 16'd5, 1'b1, 16'd0, 8'd13},  // R13
    '{1'b0, 8'd0,   8'd6,   16'd0, 1'b0, 8'd0, 16'd0, 1'b1, 16'd0, 8'd5 },  // R5
    '{1'b0, 8'd0,   8'd7,   16'd0, 1'b0, 8'd0, 16'd0, 1'b0, 16'd3, 8'd4 },  // R4
    '{1'b1, 8'hFF,  8'hFF,  16'd7, 1'b0, 8'd0, 16'd0, 1'b1, 16'd0, 8'd3 }   // R3
  };

  task automatic idle();
    dispValid = '0; dispTag = '0; dispDst = '0; dispSrc1 = '0; dispSrc2 = '0;
    cmplValid = '0; cmplReg = '0; cmplTag = '0;
  endtask

  task automatic chk(input string req, input string what, input logic actRdy,
                     input logic [15:0] actTag, input logic expRdy, input logic [15:0] expTag);
    checks++;
    if (actRdy !== expRdy || (!expRdy && actTag !== expTag)) begin
      errors++;
      $display("FAIL %s %s: actual ready=%0b tag=%0d, expected ready=%0b tag=%0d",
               req, what, actRdy, actTag, expRdy, expTag);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual run still going, expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state seen through lookups
    @(negedge clk);
    idle();
    dispSrc1 = {8'd3, 8'd127, 8'd64, 8'd0};
    dispSrc2 = {8'd100, 8'd126, 8'd2, 8'd1};
    #5;
    for (int i = 0; i < DispWidth; i++) begin
      chk("R1", "reset src1", src1Ready[i], src1Tag[i], 1'b1, 16'd0);
      chk("R1", "reset src2", src2Ready[i], src2Tag[i], 1'b1, 16'd0);
    end

    // vector table
    for (int k = 0; k < NVec; k++) begin
      @(negedge clk);
      idle();
      dispValid[0] = Vecs[k].v;   dispDst[0] = Vecs[k].dst;
      dispSrc1[0]  = Vecs[k].src; dispTag[0] = Vecs[k].tag;
      cmplValid[0] = Vecs[k].cv;  cmplReg[0] = Vecs[k].creg; cmplTag[0] = Vecs[k].ctag;
      #5;
      chk($sformatf("R%0d", Vecs[k].req), $sformatf("vector %0d", k),
          src1Ready[0], src1Tag[0], Vecs[k].expRdy, Vecs[k].expTag);
      if (Vecs[k].src[7]) begin
        checks++;
        if (src1Tag[0] !== 16'd0) begin
          errors++;
          $display("FAIL R2 absent tag: actual %0d, expected 0", src1Tag[0]);
        end
      end
    end

    // R7 R8 R9: intra-group bypass
    @(negedge clk);
    idle();
    dispValid = 4'b1111;
    dispTag  = {16'd13, 16'd12, 16'd11, 16'd10};
    dispDst  = {8'hFF, 8'd21, 8'd20, 8'd20};
    dispSrc1 = {8'd21, 8'd21, 8'd20, 8'd20};
    dispSrc2 = {8'd30, 8'd20, 8'd21, 8'hFF};
    #5;
    chk("R8", "slot0 src1", src1Ready[0], src1Tag[0], 1'b1, 16'd0);
    chk("R2", "slot0 src2", src2Ready[0], 16'd0, 1'b1, 16'd0);
    chk("R7", "slot1 src1", src1Ready[1], src1Tag[1], 1'b0, 16'd10);
    chk("R8", "slot1 src2", src2Ready[1], src2Tag[1], 1'b1, 16'd0);
    chk("R8", "slot2 src1", src1Ready[2], src1Tag[2], 1'b1, 16'd0);
    chk("R7", "slot2 src2", src2Ready[2], src2Tag[2], 1'b0, 16'd11);
    chk("R7", "slot3 src1", src1Ready[3], src1Tag[3], 1'b0, 16'd12);
    chk("R7", "slot3 src2", src2Ready[3], src2Tag[3], 1'b1, 16'd0);
    @(negedge clk);
    idle();
    dispSrc1[0] = 8'd20; dispSrc2[0] = 8'd21;
    #5;
    chk("R9", "reg20 youngest tag", src1Ready[0], src1Tag[0], 1'b0, 16'd11);
    chk("R4", "reg21 tag", src2Ready[0], src2Tag[0], 1'b0, 16'd12);

    // R11: several completion lanes at once, one of them stale
    @(negedge clk);
    idle();
    cmplValid[2:0] = 3'b111;
    cmplReg[0] = 8'd20; cmplTag[0] = 16'd11;
    cmplReg[1] = 8'd21; cmplTag[1] = 16'd12;
    cmplReg[2] = 8'd20; cmplTag[2] = 16'd10;
    @(negedge clk);
    idle();
    dispSrc1[0] = 8'd20; dispSrc2[0] = 8'd21;
    #5;
    chk("R11", "reg20 after lanes", src1Ready[0], src1Tag[0], 1'b1, 16'd0);
    chk("R11", "reg21 after lanes", src2Ready[0], src2Tag[0], 1'b1, 16'd0);

    // R12: invalid slot neither writes nor bypasses
    @(negedge clk);
    idle();
    dispValid = 4'b1001;
    dispTag  = {16'd72, 16'd71, 16'd0, 16'd70};
    dispDst  = {8'hFF, 8'd40, 8'd0, 8'd41};
    dispSrc1 = {8'd40, 8'd0, 8'd0, 8'hFF};
    dispSrc2 = {8'hFF, 8'hFF, 8'hFF, 8'hFF};
    #5;
    chk("R12", "no bypass from invalid slot", src1Ready[3], src1Tag[3], 1'b1, 16'd0);
    @(negedge clk);
    idle();
    dispSrc1[0] = 8'd40; dispSrc2[0] = 8'd41;
    #5;
    chk("R12", "invalid slot no write", src1Ready[0], src1Tag[0], 1'b1, 16'd0);
    chk("R4", "reg41 pending", src2Ready[0], src2Tag[0], 1'b0, 16'd70);

    // R3: negative destinations must not alias onto real registers
    @(negedge clk);
    idle();
    dispValid = 4'b0011;
    dispTag[0] = 16'd60; dispDst[0] = 8'hFF;
    dispTag[1] = 16'd61; dispDst[1] = 8'h80;
    @(negedge clk);
    idle();
    dispSrc1[0] = 8'd127; dispSrc2[0] = 8'd0;
    #5;
    chk("R3", "reg127 untouched", src1Ready[0], src1Tag[0], 1'b1, 16'd0);
    chk("R3", "reg0 untouched", src2Ready[0], src2Tag[0], 1'b1, 16'd0);

    @(negedge clk);
    idle();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule